// File: doc/BRIEF.md
# Stochastic Ternary Weight Updater

This block applies one training step to a ternary synapse weight without keeping a full-precision copy of that weight. Each request carries the present weight, which is one of -1, 0 or +1, and a signed fixed-point gradient. The gradient is split into an integer part and a fractional remainder. The integer part is always applied. One extra unit step, in the direction of the gradient, is added with a probability that follows a tanh curve of the remainder. The sum is then clamped back to the ternary range, so the stored weight stays ternary after every update.

The random draws come from an internal linear-feedback shift register that advances once per accepted request. Its seed can be loaded, so a run can be reproduced exactly.

Alongside the new weight the block produces two write-pulse descriptors, each a sign and a duration in cycles, capped at a fixed write window. The first cell's pulse follows the raw gradient. The second cell's pulse follows the residue: the gradient minus the step that was actually applied. Requests and results each use a valid/ready handshake, and one result register sits between them.

Top module: `tern_weight_updater`

## Requirements
- R1: Ternary values use a 2-bit code: 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. An input weight of 2'b10 is read as 0. The weight and sign outputs never carry 2'b10 while rsp_valid is high.
- R2: req_ready equals (not seed_load) and (rsp_valid low or rsp_ready high). The result of a request accepted at a clock edge appears with rsp_valid high after that edge. While rsp_valid is high and rsp_ready is low, every result output holds its value.
- R3: grad_in is two's complement with GRAD_W=8 bits, 4 of them fractional. Let s be its sign, mag its magnitude, k = mag/16 and v = mag mod 16.
- R4: The weight increment is s*(k+b). Here b=1 exactly when the 8-bit random value is below P[v], where P for v=0..15 is 0,32,63,92,118,142,163,180,195,207,217,225,232,237,241,244 (about 256*tanh(v/8)).
- R5: The random source is a 16-bit register q with next state {q[14:0], q[15]^q[13]^q[12]^q[10]}. The random value of a request is q[7:0] as it stands when the request is accepted. q advances once per accepted request and at no other time.
- R6: While seed_load is high, no request is accepted. At the edge, q takes seed_value, and a seed_value of 0 loads 1 instead.
- R7: The new weight is the old weight plus the increment, clamped to the range -1..+1.
- R8: The first cell's pulse length is min(mag/4, 15). Its sign is the sign of the gradient, or 0 when the length is 0.
- R9: Let d be the gradient minus 16 times the increment, in units of 1/16. The second cell's pulse length is min(|d|/4, 15). Its sign is the sign of d, or 0 when the length is 0.
- R10: After reset, rsp_valid is low, the result outputs are zero and q holds 16'hACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load seed_value into the random register |
| seed_value | input | 16 | Seed to load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| weight_in | input | 2 | Present ternary weight |
| grad_in | input | 8 | Signed gradient, 4 fractional bits |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| weight_out | output | 2 | Updated ternary weight |
| left_sign | output | 2 | First cell pulse sign (ternary code) |
| left_len | output | 4 | First cell pulse length in cycles |
| right_sign | output | 2 | Second cell pulse sign (ternary code) |
| right_len | output | 4 | Second cell pulse length in cycles |

## Verification
Gradients that are exact integers (v=0) and gradients of zero show that the deterministic part is applied with no random step. A remainder of 15 tried under seeds that give random values of 1 and 255 separates the two outcomes of the comparison against the probability table. Large positive and negative gradients, including -128 and 127, applied to every starting weight test the clamping and the saturation of both pulse lengths. A long run of varied weights and gradients, with idle gaps, a stalled consumer and seed reloads, tests the random sequence and shows that it advances only on accepted requests.

// File: rtl/tern_upd_pkg.sv
package tern_upd_pkg;

   typedef enum logic [1:0] {
      TRIT_ZERO = 2'b00,
      TRIT_POS  = 2'b01,
      TRIT_BAD  = 2'b10,
      TRIT_NEG  = 2'b11
   } trit_e;

   // Step probability, about 256*tanh(idx/8), clipped to 8 bits.
   function automatic logic [7:0] tanh_prob(input logic [3:0] idx);
      logic [7:0] p;
      case (idx)
         4'd0:    p = 8'd0;
         4'd1:    p = 8'd32;
         4'd2:    p = 8'd63;
         4'd3:    p = 8'd92;
         4'd4:    p = 8'd118;
         4'd5:    p = 8'd142;
         4'd6:    p = 8'd163;
         4'd7:    p = 8'd180;
         4'd8:    p = 8'd195;
         4'd9:    p = 8'd207;
         4'd10:   p = 8'd217;
         4'd11:   p = 8'd225;
         4'd12:   p = 8'd232;
         4'd13:   p = 8'd237;
         4'd14:   p = 8'd241;
         default: p = 8'd244;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/tern_upd_lfsr.sv
module tern_upd_lfsr #(
   parameter int          W         = 16,
   parameter logic [W-1:0] TAPS      = 16'hB400,
   parameter logic [W-1:0] SEED_INIT = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] state
);
   logic [W-1:0] q;
   logic         fb;

   assign fb    = ^(q & TAPS);
   assign state = q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= SEED_INIT;
      end else if (load) begin
         q <= (load_val == '0) ? {{(W-1){1'b0}}, 1'b1} : load_val;
      end else if (step) begin
         q <= {q[W-2:0], fb};
      end
   end
endmodule

// File: rtl/tern_upd_step.sv
module tern_upd_step
   import tern_upd_pkg::*;
#(
   parameter int GRAD_W = 8,
   parameter int FRAC   = 4,
   parameter int RND_W  = 8
) (
   input  logic [1:0]                     w_in,
   input  logic [GRAD_W-1:0]              grad,
   input  logic [RND_W-1:0]               rnd,
   output logic [1:0]                     w_new,
   output logic signed [GRAD_W-FRAC+1:0]  inc
);
   localparam int INT_W = GRAD_W - FRAC;
   localparam int INC_W = INT_W + 2;

   logic                    neg;
   logic [GRAD_W-1:0]       mag;
   logic [INT_W-1:0]        k_int;
   logic [FRAC-1:0]         frac_v;
   logic                    take;
   logic [INT_W:0]          inc_mag;
   logic signed [INC_W:0]   w_val;
   logic signed [INC_W:0]   sum;

   always_comb begin
      neg     = grad[GRAD_W-1];
      mag     = neg ? (~grad + 1'b1) : grad;
      k_int   = mag[GRAD_W-1:FRAC];
      frac_v  = mag[FRAC-1:0];
      take    = rnd < tanh_prob(frac_v);
      inc_mag = {1'b0, k_int} + {{INT_W{1'b0}}, take};
      inc     = neg ? -$signed({1'b0, inc_mag}) : $signed({1'b0, inc_mag});
      case (trit_e'(w_in))
         TRIT_POS: w_val = 1;
         TRIT_NEG: w_val = -1;
         default:  w_val = 0;
      endcase
      sum = w_val + $signed({inc[INC_W-1], inc});
      if (sum[INC_W])      w_new = TRIT_NEG;
      else if (sum == 0)   w_new = TRIT_ZERO;
      else                 w_new = TRIT_POS;
   end
endmodule

// File: rtl/tern_upd_pulse.sv
module tern_upd_pulse
   import tern_upd_pkg::*;
#(
   parameter int VAL_W = 10,
   parameter int SHIFT = 2,
   parameter int WIN   = 15,
   parameter int LEN_W = 4
) (
   input  logic signed [VAL_W-1:0] val,
   output logic [1:0]              sign,
   output logic [LEN_W-1:0]        len
);
   logic [VAL_W-1:0] mag;
   logic [VAL_W-1:0] scaled;

   always_comb begin
      mag    = val[VAL_W-1] ? (~val + 1'b1) : val;
      scaled = mag >> SHIFT;
      len    = (scaled > VAL_W'(WIN)) ? LEN_W'(WIN) : scaled[LEN_W-1:0];
      if (len == '0)          sign = TRIT_ZERO;
      else if (val[VAL_W-1])  sign = TRIT_NEG;
      else                    sign = TRIT_POS;
   end
endmodule

// File: rtl/tern_weight_updater.sv
module tern_weight_updater
   import tern_upd_pkg::*;
#(
   parameter int                GRAD_W      = 8,
   parameter int                FRAC        = 4,
   parameter int                LFSR_W      = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS   = 16'hB400,
   parameter logic [LFSR_W-1:0] SEED_INIT   = 16'hACE1,
   parameter int                RND_W       = 8,
   parameter int                WIN         = 15,
   parameter int                PULSE_SHIFT = 2,
   parameter int                LEN_W       = $clog2(WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load,
   input  logic [LFSR_W-1:0] seed_value,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        weight_in,
   input  logic [GRAD_W-1:0] grad_in,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        weight_out,
   output logic [1:0]        left_sign,
   output logic [LEN_W-1:0]  left_len,
   output logic [1:0]        right_sign,
   output logic [LEN_W-1:0]  right_len
);
   localparam int INC_W = GRAD_W - FRAC + 2;
   localparam int DW    = GRAD_W + 2;

   // Elaboration-time parameter checks
   if (FRAC != 4) begin : g_bad_frac
      $error("FRAC must be 4: the probability table has 16 entries");
   end
   if (RND_W != 8) begin : g_bad_rnd
      $error("RND_W must be 8 to match the 8-bit probabilities");
   end
   if (RND_W > LFSR_W) begin : g_bad_lfsr
      $error("LFSR_W must cover RND_W");
   end
   if (GRAD_W < FRAC + 2) begin : g_bad_grad
      $error("GRAD_W needs at least two integer bits");
   end
   if (LEN_W < $clog2(WIN + 1)) begin : g_bad_len
      $error("LEN_W too narrow for WIN");
   end

   logic                    accept;
   logic [LFSR_W-1:0]       lfsr_q;
   logic [1:0]              w_next;
   logic signed [INC_W-1:0] inc;
   logic signed [DW-1:0]    cell_val  [2];
   logic [1:0]              cell_sign [2];
   logic [LEN_W-1:0]        cell_len  [2];
   logic signed [DW-1:0]    grad_ext;
   logic signed [DW-1:0]    inc_ext;

   assign req_ready = !seed_load && (!rsp_valid || rsp_ready);
   assign accept    = req_valid && req_ready;

   tern_upd_lfsr #(
      .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED_INIT(SEED_INIT)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(seed_load), .load_val(seed_value),
      .step(accept), .state(lfsr_q)
   );

   tern_upd_step #(
      .GRAD_W(GRAD_W), .FRAC(FRAC), .RND_W(RND_W)
   ) u_step (
      .w_in(weight_in), .grad(grad_in), .rnd(lfsr_q[RND_W-1:0]),
      .w_new(w_next), .inc(inc)
   );

   assign grad_ext    = {{2{grad_in[GRAD_W-1]}}, grad_in};
   assign inc_ext     = {{(DW-INC_W){inc[INC_W-1]}}, inc};
   assign cell_val[0] = grad_ext;
   assign cell_val[1] = grad_ext - (inc_ext <<< FRAC);

   for (genvar c = 0; c < 2; c++) begin : g_cell
      tern_upd_pulse #(
         .VAL_W(DW), .SHIFT(PULSE_SHIFT), .WIN(WIN), .LEN_W(LEN_W)
      ) u_pulse (
         .val(cell_val[c]), .sign(cell_sign[c]), .len(cell_len[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         weight_out <= TRIT_ZERO;
         left_sign  <= TRIT_ZERO;
         left_len   <= '0;
         right_sign <= TRIT_ZERO;
         right_len  <= '0;
      end else if (accept) begin
         rsp_valid  <= 1'b1;
         weight_out <= w_next;
         left_sign  <= cell_sign[0];
         left_len   <= cell_len[0];
         right_sign <= cell_sign[1];
         right_len  <= cell_len[1];
      end else if (rsp_ready) begin
         rsp_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/tern_upd_chk.sv
module tern_upd_chk #(
   parameter int GRAD_W = 8,
   parameter int WIN    = 15,
   parameter int LEN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        weight_in,
   input logic [GRAD_W-1:0] grad_in,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [1:0]        weight_out,
   input logic [1:0]        left_sign,
   input logic [LEN_W-1:0]  left_len,
   input logic [1:0]        right_sign,
   input logic [LEN_W-1:0]  right_len
);
   logic acc;
   assign acc = req_valid && req_ready;

   assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (weight_out != 2'b10 && left_sign != 2'b10 && right_sign != 2'b10));

   assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   assert_hold_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(weight_out) && $stable(left_sign)
         && $stable(left_len) && $stable(right_sign) && $stable(right_len)));

   assert_clamp_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && weight_in == 2'b01 && !grad_in[GRAD_W-1]) |=> weight_out == 2'b01);

   assert_clamp_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && weight_in == 2'b11 && grad_in[GRAD_W-1]) |=> weight_out == 2'b11);

   assert_left_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (left_len <= LEN_W'(WIN) && ((left_len == '0) == (left_sign == 2'b00))));

   assert_right_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (right_len <= LEN_W'(WIN) && ((right_len == '0) == (right_sign == 2'b00))));
endmodule

bind tern_weight_updater tern_upd_chk #(
   .GRAD_W(GRAD_W), .WIN(WIN), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .weight_in(weight_in), .grad_in(grad_in), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .weight_out(weight_out), .left_sign(left_sign),
   .left_len(left_len), .right_sign(right_sign), .right_len(right_len)
);

// File: tb/tern_weight_updater_tb.sv
module tern_weight_updater_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [15:0] seed_value = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  weight_in = '0;
   logic [7:0]  grad_in = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [1:0]  weight_out, left_sign, right_sign;
   logic [3:0]  left_len, right_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   tern_weight_updater u_dut (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
      .req_valid(req_valid), .req_ready(req_ready), .weight_in(weight_in),
      .grad_in(grad_in), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .weight_out(weight_out), .left_sign(left_sign), .left_len(left_len),
      .right_sign(right_sign), .right_len(right_len)
   );

   typedef struct {
      logic [1:0] w;
      logic [1:0] ls;
      int         ll;
      logic [1:0] rs;
      int         rl;
      string      tag;
   } exp_t;

   exp_t        exp_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;
   logic [15:0] model = 16'hACE1;

   function automatic int trit_val(logic [1:0] e);
      if (e == 2'b01) return 1;
      if (e == 2'b11) return -1;
      return 0;
   endfunction

   function automatic logic [1:0] trit_enc(int v);
      if (v > 0) return 2'b01;
      if (v < 0) return 2'b11;
      return 2'b00;
   endfunction

   function automatic int prob(int i);
      int tbl [16] = '{0, 32, 63, 92, 118, 142, 163, 180, 195, 207, 217, 225, 232, 237, 241, 244};
      return tbl[i];
   endfunction

   function automatic logic [15:0] lfsr_next(logic [15:0] q);
      return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // Driver: present one request, predict its result, push it.
   task automatic send(input logic [1:0] w, input int g, input string tag);
      exp_t e;
      int s, mag, k, v, b, inc, nw, d, dm;
      @(negedge clk);
      req_valid = 1'b1;
      weight_in = w;
      grad_in   = g[7:0];
      while (!req_ready) @(negedge clk);
      s   = (g > 0) ? 1 : ((g < 0) ? -1 : 0);
      mag = (g < 0) ? -g : g;
      k   = mag / 16;
      v   = mag % 16;
      b   = (int'(model[7:0]) < prob(v)) ? 1 : 0;
      inc = s * (k + b);
      nw  = trit_val(w) + inc;
      if (nw > 1)  nw = 1;
      if (nw < -1) nw = -1;
      d   = g - 16 * inc;
      dm  = (d < 0) ? -d : d;
      e.w   = trit_enc(nw);
      e.ll  = (mag / 4 > 15) ? 15 : mag / 4;
      e.ls  = (e.ll == 0) ? 2'b00 : trit_enc(s);
      e.rl  = (dm / 4 > 15) ? 15 : dm / 4;
      e.rs  = (e.rl == 0) ? 2'b00 : trit_enc(d);
      e.tag = tag;
      exp_q.push_back(e);
      model = lfsr_next(model);
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic load_seed(input logic [15:0] v);
      @(negedge clk);
      seed_load  = 1'b1;
      seed_value = v;
      #1 check(req_ready == 1'b0, "R6", "ready low during seed load", req_ready, 0);
      @(posedge clk);
      #1 seed_load = 1'b0;
      model = (v == 16'h0) ? 16'h0001 : v;
   endtask

   // Monitor: compare each delivered result with the head of the queue.
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (exp_q.size() == 0) begin
            check(0, "R2", "response with nothing expected", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(weight_out == e.w, {e.tag, "/R7"}, "weight_out",
                  trit_val(weight_out), trit_val(e.w));
            check(left_sign == e.ls, "R8", "left_sign", trit_val(left_sign), trit_val(e.ls));
            check(int'(left_len) == e.ll, "R8", "left_len", left_len, e.ll);
            check(right_sign == e.rs, "R9", "right_sign", trit_val(right_sign), trit_val(e.rs));
            check(int'(right_len) == e.rl, "R9", "right_len", right_len, e.rl);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [1:0] held;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);
      check(weight_out == 2'b00, "R10", "weight_out after reset", weight_out, 0);
      check(req_ready == 1'b1, "R2", "req_ready when idle", req_ready, 1);

      // First draws use the reset seed (R10, R5)
      send(2'b00, 24, "R10");
      send(2'b01, 0, "R3");
      send(2'b11, 0, "R3");
      send(2'b10, 0, "R1");              // 2'b10 read as 0
      send(2'b10, 16, "R1");
      send(2'b00, 16, "R4");             // v=0: exactly one step
      send(2'b00, -16, "R4");
      send(2'b01, 127, "R7");
      send(2'b11, -128, "R7");
      send(2'b11, 40, "R7");
      send(2'b01, -40, "R7");
      send(2'b00, 3, "R8");
      send(2'b00, -5, "R8");

      // R6: zero seed loads 1, random value 1 < 244 so the step is taken
      load_seed(16'h0000);
      send(2'b00, 15, "R6");
      // R4: random value 255 is not below 244, no step
      load_seed(16'h00FF);
      send(2'b00, 15, "R4");
      send(2'b00, -15, "R4");

      // R5: idle cycles do not advance the random register
      repeat (5) @(posedge clk);
      send(2'b00, 9, "R5");
      repeat (3) @(posedge clk);
      send(2'b01, -9, "R5");

      // R2: stalled consumer holds the result and blocks requests
      repeat (2) @(posedge clk);
      #1 rsp_ready = 1'b0;
      send(2'b00, 100, "R2");
      held = weight_out;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(rsp_valid == 1'b1, "R2", "rsp_valid held", rsp_valid, 1);
         check(req_ready == 1'b0, "R2", "req_ready low when stalled", req_ready, 0);
         check(weight_out == held, "R2", "weight_out stable", weight_out, held);
      end
      @(posedge clk);
      #1 rsp_ready = 1'b1;

      // Broad sweep with occasional reseeds (R3, R4, R5)
      for (int n = 0; n < 400; n++) begin
         int g;
         logic [1:0] w;
         g = int'($urandom_range(255)) - 128;
         case ($urandom_range(3))
            0: w = 2'b00;
            1: w = 2'b01;
            2: w = 2'b11;
            default: w = 2'b10;
         endcase
         if (n % 97 == 50) load_seed(16'($urandom_range(65535)));
         send(w, g, "R4");
         if (n % 13 == 0) @(posedge clk);
      end

      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      summary();
   end
endmodule